// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block runs the output-strength calibration of a memory PHY without software in the loop. After a start pulse it enables the analog calibration circuit and clears both drive code fields. It then runs three searches in a fixed order: pull-up drive, pull-down drive and pull-down termination. Each search steps a 5-bit code upward from zero. After every step it waits a settle interval and then reads a one-bit comparator. The search stops at the first code where the comparator shows the level that search is looking for.

Each search also drives a reference-voltage select code and a pair of leg enables into the analog side. The reference code is looked up from the current search and from whether termination is on. When all three searches have finished, the block publishes four result codes and three fail flags and pulses done. The pull-up termination search does not exist, so its result reads zero. A search that reaches the top code without stopping reports the top code and raises its fail flag.

Top module: `imp_cal_seq`

## Requirements
- R1: After reset, all four result outputs read 0xFF, done, busy, cal_en, both leg enables and all fail flags are 0, and both code outputs are 0.
- R2: On the clock edge after start is seen while idle, busy and cal_en rise and both code outputs read 0. Both leg enables then stay 0 for SETTLE_CYC+1 cycles, and only after that does the pull-up search begin.
- R3: The searches run in the order pull-up (en_p=1, en_n=0), pull-down drive (en_p=0, en_n=0), termination (en_p=0, en_n=1). en_p and en_n are never high together.
- R4: Each code value is held for at least SETTLE_CYC+1 cycles before it is judged. The comparator input reaches the decision through a two-flop synchronizer, so SETTLE_CYC must be at least 2.
- R5: The pull-up search steps drv_p_code upward from 0 by one. Its result is the first code at which the synchronized comparator reads 1.
- R6: The pull-down drive search and the termination search each step drv_n_code upward from 0. Each result is the first code at which the comparator reads 0.
- R7: A search with no stopping code from 0 to 31 gives the result 31 and sets its own fail flag (fail_pu, fail_pd or fail_tn). A search that does stop clears its flag.
- R8: During the pull-up search, drv_n_code reads 0. During both pull-down searches, drv_p_code holds the pull-up result.
- R9: While busy, vref_sel is 0x37 (termination off) or 0x3A (termination on) in the pull-up and termination searches, and 0x33 in the pull-down drive search. While idle it is 0.
- R10: At the end of a run, res_tp reads 0.
- R11: done is high for exactly one cycle per run. The results and fail flags change only in the cycle where done is high and stay stable at all other times.
- R12: A start pulse while busy is ignored. The run in progress completes once, with unchanged results, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a run when idle |
| odt_on | input | 1 | Termination state used for the reference lookup |
| cmp_in | input | 1 | Asynchronous comparator output from the analog circuit |
| drv_p_code | output | CODE_W | Pull-up drive code to the analog circuit |
| drv_n_code | output | CODE_W | Pull-down drive code to the analog circuit |
| vref_sel | output | 6 | Reference-voltage select code |
| cal_en | output | 1 | Calibration circuit enable |
| en_p | output | 1 | Pull-up leg enable |
| en_n | output | 1 | Pull-down termination leg enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| res_pu | output | RES_W | Pull-up drive result |
| res_pd | output | RES_W | Pull-down drive result |
| res_tp | output | RES_W | Pull-up termination result (always 0 after a run) |
| res_tn | output | RES_W | Pull-down termination result |
| fail_pu | output | 1 | Pull-up search saturated |
| fail_pd | output | 1 | Pull-down drive search saturated |
| fail_tn | output | 1 | Termination search saturated |

## Verification
The bench builds the block with SETTLE_CYC=4. A full three-search sweep then fits in a few hundred cycles, so searches that stop at code 0, at code 31, in the middle and nowhere can all be run in one short bench. A settle of 4 is still two cycles longer than the synchronizer latency. The comparator is therefore modelled as a plain threshold on the live code outputs, and a wrong settle or sync count shows up as an off-by-one result. With the short interval, the exact length of the initial wait can also be counted cycle by cycle.

// File: rtl/imp_cal_pkg.sv
// Shared types and reference lookup for the impedance calibration sequencer.
// Assumes three active searches; the pull-up termination search is never run.
package imp_cal_pkg;

    localparam int VREF_W = 6;

    typedef enum logic [1:0] {
        PH_PU = 2'd0,
        PH_PD = 2'd1,
        PH_TN = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INIT  = 2'd1,
        ST_SWEEP = 2'd2
    } state_e;

    // Reference code for a given termination state and search.
    function automatic logic [VREF_W-1:0] vref_lookup(input logic odt, input phase_e ph);
        logic [VREF_W-1:0] v;
        case (ph)
            PH_PD:   v = 6'h33;
            PH_PU,
            PH_TN:   v = odt ? 6'h3A : 6'h37;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/imp_cal_sync.sv
// Multi-flop synchronizer for the asynchronous comparator bit.
// Assumes STAGES >= 2; reset value is 0.
module imp_cal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/imp_cal_timer.sv
// Settle-interval down-counter. A load sets it to LOAD_VAL, and it then counts
// down to zero and holds there. Assumes LOAD_VAL fits in CNT_W bits.
module imp_cal_timer #(
    parameter int LOAD_VAL = 200,
    parameter int CNT_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD_VAL);

    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LOAD_V;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/imp_cal_vref.sv
// Reference select output stage: table value while active, zero while idle.
// Assumes the phase input is one of the three active searches.
module imp_cal_vref
    import imp_cal_pkg::*;
(
    input  logic              active,
    input  logic              odt_on,
    input  phase_e            phase,
    output logic [VREF_W-1:0] vref
);
    // Pick the reference code for the running search.
    always_comb vref = active ? vref_lookup(odt_on, phase) : '0;
endmodule

// File: rtl/imp_cal_seq.sv
// Impedance calibration sequencer: runs the pull-up, pull-down drive and
// termination searches in turn. Each one steps a code upward and stops on the
// search's comparator level, then results are published with a done pulse.
// Assumes SETTLE_CYC >= 2 (covers synchronizer latency) and cmp_in follows
// the code outputs combinationally in the analog circuit.
module imp_cal_seq
    import imp_cal_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int RES_W      = 8,
    parameter int SETTLE_CYC = 200,
    parameter int SYNC_STG   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            odt_on,
    input  logic                            cmp_in,
    output logic [CODE_W-1:0]               drv_p_code,
    output logic [CODE_W-1:0]               drv_n_code,
    output logic [imp_cal_pkg::VREF_W-1:0]  vref_sel,
    output logic                            cal_en,
    output logic                            en_p,
    output logic                            en_n,
    output logic                            busy,
    output logic                            done,
    output logic [RES_W-1:0]                res_pu,
    output logic [RES_W-1:0]                res_pd,
    output logic [RES_W-1:0]                res_tp,
    output logic [RES_W-1:0]                res_tn,
    output logic                            fail_pu,
    output logic                            fail_pd,
    output logic                            fail_tn
);
    localparam int               CNT_W    = $clog2(SETTLE_CYC + 1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam int               PAD_W    = RES_W - CODE_W;

    state_e            st;
    phase_e            ph;
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] pu_hold;
    logic [CODE_W-1:0] pd_hold;
    logic              f_pu_w;
    logic              f_pd_w;
    logic              cmp_s;
    logic              tmr_load;
    logic              tmr_zero;
    logic              target;
    logic              hit;
    logic              judge;
    logic              stop;
    logic              last;

    imp_cal_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_in),
        .q     (cmp_s)
    );

    imp_cal_timer #(.LOAD_VAL(SETTLE_CYC), .CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_zero)
    );

    imp_cal_vref u_vref (
        .active (busy),
        .odt_on (odt_on),
        .phase  (ph),
        .vref   (vref_sel)
    );

    // Stop level and decision for the current code.
    always_comb begin
        target = (ph == PH_PU);
        hit    = (cmp_s == target);
        judge  = (st == ST_SWEEP) && tmr_zero;
        stop   = judge && (hit || (code == CODE_MAX));
        last   = stop && (ph == PH_TN);
    end

    // Restart the settle interval on start, on leaving the init wait and on each new code.
    always_comb tmr_load = ((st == ST_IDLE) && start)
                        || ((st == ST_INIT) && tmr_zero)
                        || (judge && !last);

    // Sequencer state, sweep code, per-search holds and published results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ph      <= PH_PU;
            code    <= '0;
            pu_hold <= '0;
            pd_hold <= '0;
            f_pu_w  <= 1'b0;
            f_pd_w  <= 1'b0;
            res_pu  <= '1;
            res_pd  <= '1;
            res_tp  <= '1;
            res_tn  <= '1;
            fail_pu <= 1'b0;
            fail_pd <= 1'b0;
            fail_tn <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st      <= ST_INIT;
                        ph      <= PH_PU;
                        code    <= '0;
                        pu_hold <= '0;
                        pd_hold <= '0;
                    end
                end
                ST_INIT: begin
                    if (tmr_zero) st <= ST_SWEEP;
                end
                ST_SWEEP: begin
                    if (stop) begin
                        code <= '0;
                        case (ph)
                            PH_PU: begin
                                pu_hold <= code;
                                f_pu_w  <= !hit;
                                ph      <= PH_PD;
                            end
                            PH_PD: begin
                                pd_hold <= code;
                                f_pd_w  <= !hit;
                                ph      <= PH_TN;
                            end
                            default: begin
                                code    <= code;
                                st      <= ST_IDLE;
                                done    <= 1'b1;
                                res_pu  <= {{PAD_W{1'b0}}, pu_hold};
                                res_pd  <= {{PAD_W{1'b0}}, pd_hold};
                                res_tp  <= '0;
                                res_tn  <= {{PAD_W{1'b0}}, code};
                                fail_pu <= f_pu_w;
                                fail_pd <= f_pd_w;
                                fail_tn <= !hit;
                            end
                        endcase
                    end else if (judge) begin
                        code <= code + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Analog-side controls derived from state and search.
    always_comb begin
        busy       = (st != ST_IDLE);
        cal_en     = busy;
        en_p       = (st == ST_SWEEP) && (ph == PH_PU);
        en_n       = (st == ST_SWEEP) && (ph == PH_TN);
        drv_p_code = ((st == ST_SWEEP) && (ph == PH_PU)) ? code : pu_hold;
        drv_n_code = (ph == PH_PU) ? '0 : code;
    end
endmodule

// File: rtl/imp_cal_chk.sv
// Checker for imp_cal_seq: leg exclusivity, settle hold, pull-up hold,
// saturation, done pulse and result stability. Bound into every instance.
module imp_cal_chk #(
    parameter int CODE_W     = 5,
    parameter int RES_W      = 8,
    parameter int SETTLE_CYC = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              en_p,
    input logic              en_n,
    input logic [CODE_W-1:0] drv_p_code,
    input logic [CODE_W-1:0] drv_n_code,
    input logic [RES_W-1:0]  res_pu,
    input logic [RES_W-1:0]  res_pd,
    input logic [RES_W-1:0]  res_tp,
    input logic [RES_W-1:0]  res_tn,
    input logic              fail_pu,
    input logic              fail_pd,
    input logic              fail_tn
);
    localparam int HOLD_W = $clog2(SETTLE_CYC + 2) + 1;
    localparam logic [RES_W-1:0] RES_SAT = RES_W'((1 << CODE_W) - 1);

    logic [2*CODE_W-1:0] cat;
    logic [2*CODE_W-1:0] cat_q;
    logic [HOLD_W-1:0]   hold;

    assign cat = {drv_p_code, drv_n_code};

    // Count cycles since the code outputs last changed, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cat_q <= '0;
            hold  <= '0;
        end else begin
            cat_q <= cat;
            if (cat != cat_q)              hold <= '0;
            else if (int'(hold) < SETTLE_CYC) hold <= hold + 1'b1;
        end
    end

    // R3
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(en_p && en_n));

    // R4
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cat != cat_q)) |-> (int'(hold) >= SETTLE_CYC));

    // R8
    pu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> $stable(drv_p_code));

    // R7
    pu_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail_pu) |-> (res_pu == RES_SAT));

    // R7
    tn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail_tn) |-> (res_tn == RES_SAT));

    // R10
    tp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_tp == '0));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({res_pu, res_pd, res_tp, res_tn, fail_pu, fail_pd, fail_tn}));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind imp_cal_seq imp_cal_chk #(
    .CODE_W     (CODE_W),
    .RES_W      (RES_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .en_p       (en_p),
    .en_n       (en_n),
    .drv_p_code (drv_p_code),
    .drv_n_code (drv_n_code),
    .res_pu     (res_pu),
    .res_pd     (res_pd),
    .res_tp     (res_tp),
    .res_tn     (res_tn),
    .fail_pu    (fail_pu),
    .fail_pd    (fail_pd),
    .fail_tn    (fail_tn)
);

// File: tb/sim_imp_cal_seq.sv
`timescale 1ns/1ps
module sim_imp_cal_seq;
    localparam int SETTLE = 4;
    localparam int CW     = 5;
    localparam int RW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          odt_on = 1'b0;
    logic          cmp_in;
    logic [CW-1:0] drv_p_code, drv_n_code;
    logic [5:0]    vref_sel;
    logic          cal_en, en_p, en_n, busy, done;
    logic [RW-1:0] res_pu, res_pd, res_tp, res_tn;
    logic          fail_pu, fail_pd, fail_tn;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int thp = 40, thn = 40, tht = 40;

    always #2.5 clk = ~clk;

    imp_cal_seq #(.CODE_W(CW), .RES_W(RW), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .odt_on(odt_on), .cmp_in(cmp_in),
        .drv_p_code(drv_p_code), .drv_n_code(drv_n_code), .vref_sel(vref_sel),
        .cal_en(cal_en), .en_p(en_p), .en_n(en_n), .busy(busy), .done(done),
        .res_pu(res_pu), .res_pd(res_pd), .res_tp(res_tp), .res_tn(res_tn),
        .fail_pu(fail_pu), .fail_pd(fail_pd), .fail_tn(fail_tn)
    );

    // Comparator model: threshold on the live code of the enabled leg.
    always_comb begin
        if (en_p)      cmp_in = (int'(drv_p_code) >= thp);
        else if (en_n) cmp_in = (int'(drv_n_code) < tht);
        else           cmp_in = (int'(drv_n_code) < thn);
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int t);
        return (t > 31) ? 31 : t;
    endfunction

    function automatic int vexp(input bit o, input int ph);
        if (ph == 1) return 'h33;
        return o ? 'h3A : 'h37;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic t_reset();
        chk(res_pu == 8'hFF && res_pd == 8'hFF && res_tp == 8'hFF && res_tn == 8'hFF,
            "R1", "results after reset", int'(res_pu), 255);
        chk(!done && !busy && !cal_en && !en_p && !en_n, "R1", "control after reset",
            int'({done, busy, cal_en, en_p, en_n}), 0);
        chk(!fail_pu && !fail_pd && !fail_tn, "R1", "fail flags after reset",
            int'({fail_pu, fail_pd, fail_tn}), 0);
        chk(drv_p_code == 0 && drv_n_code == 0, "R1", "codes after reset",
            int'({drv_p_code, drv_n_code}), 0);
    endtask

    task automatic t_init();
        bit early = 0;
        @(negedge clk); thp = 3; thn = 3; tht = 3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && cal_en, "R2", "busy/cal_en after start", int'({busy, cal_en}), 3);
        chk(drv_p_code == 0 && drv_n_code == 0, "R2", "codes cleared", int'({drv_p_code, drv_n_code}), 0);
        for (int i = 1; i <= SETTLE + 1; i++) begin
            if (en_p || en_n) early = 1;
            if (i != SETTLE + 1) @(negedge clk);
        end
        chk(!early, "R2", "leg enables low during init wait", int'(early), 0);
        @(negedge clk);
        chk(en_p == 1'b1, "R2", "pull-up search begins after init wait", int'(en_p), 1);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cal(input bit o, input int tp, input int tn, input int tt);
        bit seen_pu = 0, seen_pd = 0, seen_tn = 0, prev_ep = 0, n_bad = 0;
        int guard = 0;
        @(negedge clk);
        odt_on = o; thp = tp; thn = tn; tht = tt; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && guard < 5000) begin
            if (en_p && !seen_pu) begin
                seen_pu = 1;
                chk(vref_sel == 6'(vexp(o, 0)), "R9", "vref pull-up", int'(vref_sel), vexp(o, 0));
                chk(!seen_pd && !seen_tn, "R3", "pull-up search first", int'({seen_pd, seen_tn}), 0);
            end
            if (en_p && drv_n_code != 0) n_bad = 1;
            if (busy && !en_p && !en_n && prev_ep && !seen_pd) begin
                seen_pd = 1;
                chk(int'(drv_p_code) == sat(tp), "R8", "pull-up result held in pull-down search",
                    int'(drv_p_code), sat(tp));
                chk(vref_sel == 6'(vexp(o, 1)), "R9", "vref pull-down", int'(vref_sel), vexp(o, 1));
            end
            if (en_n && !seen_tn) begin
                seen_tn = 1;
                chk(seen_pd, "R3", "termination after pull-down", int'(seen_pd), 1);
                chk(vref_sel == 6'(vexp(o, 2)), "R9", "vref termination", int'(vref_sel), vexp(o, 2));
                chk(int'(drv_p_code) == sat(tp), "R8", "pull-up result held in termination",
                    int'(drv_p_code), sat(tp));
            end
            prev_ep = en_p;
            guard++;
            @(negedge clk);
        end
        chk(done, "R11", "done seen", int'(done), 1);
        chk(!n_bad, "R8", "pull-down code zero in pull-up search", int'(n_bad), 0);
        chk(int'(res_pu) == sat(tp), "R5", "pull-up result", int'(res_pu), sat(tp));
        chk(int'(res_pd) == sat(tn), "R6", "pull-down result", int'(res_pd), sat(tn));
        chk(int'(res_tn) == sat(tt), "R6", "termination result", int'(res_tn), sat(tt));
        chk(fail_pu == (tp > 31), "R7", "pull-up fail flag", int'(fail_pu), int'(tp > 31));
        chk(fail_pd == (tn > 31), "R7", "pull-down fail flag", int'(fail_pd), int'(tn > 31));
        chk(fail_tn == (tt > 31), "R7", "termination fail flag", int'(fail_tn), int'(tt > 31));
        chk(res_tp == 0, "R10", "skipped search result", int'(res_tp), 0);
        chk(!busy && vref_sel == 0, "R9", "idle after done, vref zero", int'({busy, vref_sel}), 0);
        @(negedge clk);
        chk(!done, "R11", "done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_busy_start();
        int dn = 0;
        @(negedge clk);
        odt_on = 1'b0; thp = 12; thn = 20; tht = 7; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (done) dn++;
            @(negedge clk);
        end
        chk(dn == 1, "R12", "one done for start while busy", dn, 1);
        chk(!busy, "R12", "idle after ignored start", int'(busy), 0);
        chk(res_pu == 12 && res_pd == 20 && res_tn == 7, "R12", "results of first run",
            int'(res_pd), 20);
    endtask

    task automatic t_stable();
        logic [RW-1:0] a = res_pu, b = res_pd, c = res_tn;
        @(negedge clk);
        thp = 1; thn = 2; tht = 3; odt_on = ~odt_on;
        repeat (100) @(negedge clk);
        chk(res_pu == a && res_pd == b && res_tn == c && !done, "R11", "results stable while idle",
            int'(res_pu), int'(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        t_reset();
        t_init();
        run_cal(1'b0, 5, 9, 17);
        run_cal(1'b1, 0, 31, 3);
        run_cal(1'b0, 32, 33, 40);
        run_cal(1'b1, 31, 0, 0);
        t_busy_start();
        t_stable();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule